// File: doc/BRIEF.md
# Event-Timer Register Bank

This block is the register file of a high-precision event timer with a parameterised number of comparator channels (three by default). It decodes a 1 KB window and holds a read-only capability word, a two-bit global configuration, a status word, the free-running main counter, and three registers for each channel: a configuration, a comparator and an interrupt routing word. Software reaches every 64-bit register with accesses of 1 to 8 bytes. A narrow read returns the addressed bytes right-justified. A narrow write replaces only the addressed byte lanes, and a per-register writable mask then decides which of the merged bits are kept.

The main counter advances by one on each cycle of `tick_en` while the global enable bit is set. It holds its value while the enable bit is clear and continues from that value when the bit is set again. A host write to the counter is taken whether or not the counter is running. The comparator match logic and the interrupt fabric sit outside this block and read the per-channel registers, the global configuration bits and the counter through dedicated output ports.

Reads are combinational from the current register state. Writes take effect at the rising clock edge on which `req_valid` and `req_write` are both high.

Top module: `evtmr_regbank`

## Requirements
- R1: Only `req_addr[9:0]` is decoded. An address with higher bits set aliases to the register at its low 10 bits.
- R2: An access is rejected when `req_len` is 0 or greater than 8, or when `req_addr[2:0] & (req_len-1)` is nonzero. A rejected read returns all-ones on `rd_data`, and a rejected write changes no register.
- R3: A read of `req_len` bytes returns the 64-bit register shifted right by 8·`req_addr[2:0]`, with every bit from 8·`req_len` upward forced to zero.
- R4: A write of `req_len` bytes replaces byte lanes `req_addr[2:0]` to `req_addr[2:0]+req_len-1` of the register with the low bytes of `req_wdata`, and leaves its other bytes unchanged.
- R5: In the global configuration at offset 0x010, only bit 0 (global enable) and bit 1 (legacy routing) are writable. All other bits read zero.
- R6: A channel configuration write changes only the bits in mask 0x3F4E. Every other bit keeps its previous value.
- R7: The capability word at offset 0x000 reads 0x8086A201 in bits [31:0] with three channels, and the tick period in femtoseconds (parameter `TICK_FS`) in bits [63:32].
- R8: After reset, each channel configuration is 0x00F0_0000_0000_0030, each comparator is all-ones, each route word is zero, and the global configuration and the counter are zero.
- R9: A channel configuration write that sets bit 8 (32-bit mode) clears bits [63:32] of that channel's comparator.
- R10: The counter at offset 0x0F0 increments by one on each clock with `tick_en` high while global enable is 1, and holds its value while global enable is 0.
- R11: A counter write is accepted while the counter runs, and it takes priority over an increment in the same cycle.
- R12: A read of an undecoded offset, or of status (0x020), returns zero. A write to an undecoded offset changes no register.
- R13: The output ports `ch_cfg`, `ch_cmp`, `ch_route` (channel n in bits [64n+63:64n]), `glb_enable` and `main_count` carry the current register values.
- R14: Channel n occupies offsets 0x100+0x20·n (configuration), 0x108+0x20·n (comparator) and 0x110+0x20·n (route).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance strobe |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Byte address; only bits [9:0] are decoded |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, right-justified |
| rd_data | output | 64 | Read data for the current address and length |
| glb_enable | output | 1 | Global enable bit |
| legacy_route | output | 1 | Legacy routing bit |
| main_count | output | 64 | Main counter value |
| ch_cfg | output | 64·NUM_CH | Channel configuration words |
| ch_cmp | output | 64·NUM_CH | Channel comparator words |
| ch_route | output | 64·NUM_CH | Channel routing words |

## Verification
`rd_data` is combinational, so the bench checks a read one time step after it drives the address and length on a falling edge, within the same cycle. A write, and each counter increment, lands at the next rising edge, so the effect is checked at the falling edge that follows it, one cycle after the stimulus. The priority test holds `tick_en` high through a counter write: the read in the first cycle afterwards must show exactly the written value, and the read in the following cycle must show that value plus one. This confirms that the load replaced the increment and that counting then resumed.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    localparam int REG_W = 64;
    localparam int WIN_W = 10;

    localparam logic [WIN_W-1:0] OFF_CAP     = 10'h000;
    localparam logic [WIN_W-1:0] OFF_GCFG    = 10'h010;
    localparam logic [WIN_W-1:0] OFF_STAT    = 10'h020;
    localparam logic [WIN_W-1:0] OFF_COUNT   = 10'h0F0;
    localparam logic [WIN_W-1:0] OFF_CH_BASE = 10'h100;

    localparam logic [4:0] SUB_CFG   = 5'h00;
    localparam logic [4:0] SUB_CMP   = 5'h08;
    localparam logic [4:0] SUB_ROUTE = 5'h10;

    localparam logic [REG_W-1:0] GCFG_WMASK = 64'h0000_0000_0000_0003;
    localparam logic [REG_W-1:0] CCFG_WMASK = 64'h0000_0000_0000_3F4E;
    localparam logic [REG_W-1:0] CCFG_RST   = 64'h00F0_0000_0000_0030;
    localparam int               MODE32_BIT = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_GCFG,
        SEL_STAT,
        SEL_COUNT,
        SEL_CCFG,
        SEL_CCMP,
        SEL_CROUTE
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] cmp;
        logic [REG_W-1:0] route;
    } chan_regs_t;

endpackage

// File: rtl/evtmr_access.sv
module evtmr_access (
    input  logic [2:0]  lo_addr,
    input  logic [3:0]  len,
    output logic        acc_ok,
    output logic [5:0]  bit_shift,
    output logic [63:0] byte_mask,
    output logic [63:0] lane_mask
);
    logic [3:0] len_m1;
    logic       len_bad;
    logic       misalign;

    always_comb begin
        len_m1    = len - 4'd1;
        len_bad   = (len == 4'd0) || (len > 4'd8);
        misalign  = |({1'b0, lo_addr} & len_m1);
        acc_ok    = !len_bad && !misalign;
        bit_shift = {lo_addr, 3'b000};
        if (len == 4'd8)
            byte_mask = '1;
        else
            byte_mask = (64'd1 << {len[2:0], 3'b000}) - 64'd1;
        lane_mask = byte_mask << bit_shift;
    end
endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q
);
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && tick_en)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && run && tick_en) |=> (cnt_q == $past(cnt_q) + W'(1)));

    // R10
    cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick_en)) |=> $stable(cnt_q));

    // R11
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/evtmr_channel.sv
module evtmr_channel
    import evtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cfg,
    input  logic             wr_cmp,
    input  logic             wr_route,
    input  logic [REG_W-1:0] wval,
    output logic [REG_W-1:0] cfg_q,
    output logic [REG_W-1:0] cmp_q,
    output logic [REG_W-1:0] route_q
);
    chan_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cfg) begin
            st_d.cfg = (wval & CCFG_WMASK) | (st_q.cfg & ~CCFG_WMASK);
            if (wval[MODE32_BIT])
                st_d.cmp = {32'd0, st_q.cmp[31:0]};
        end
        if (wr_cmp)
            st_d.cmp = wval;
        if (wr_route)
            st_d.route = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg   <= CCFG_RST;
            st_q.cmp   <= '1;
            st_q.route <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q   = st_q.cfg;
    assign cmp_q   = st_q.cmp;
    assign route_q = st_q.route;

    // R6
    cfg_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cfg_q & ~CCFG_WMASK) == ($past(cfg_q) & ~CCFG_WMASK)));

    // R9
    mode32_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && wval[MODE32_BIT]) |=> (cmp_q[63:32] == 32'd0));
endmodule

// File: rtl/evtmr_regbank.sv
module evtmr_regbank
    import evtmr_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          NUM_CH  = 3,
    parameter logic [31:0] TICK_FS = 32'd10000000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [3:0]              req_len,
    input  logic [63:0]             req_wdata,
    output logic [63:0]             rd_data,
    output logic                    glb_enable,
    output logic                    legacy_route,
    output logic [63:0]             main_count,
    output logic [NUM_CH*REG_W-1:0] ch_cfg,
    output logic [NUM_CH*REG_W-1:0] ch_cmp,
    output logic [NUM_CH*REG_W-1:0] ch_route
);
    localparam logic [REG_W-1:0] CAP_WORD =
        {TICK_FS, 16'h8086, 3'b101, 5'(NUM_CH - 1), 8'h01};

    logic [WIN_W-1:0] win_off;
    logic [WIN_W-1:0] word_off;
    logic [WIN_W-1:0] ch_rel;
    logic [4:0]       ch_idx;
    reg_sel_e         sel;
    logic             acc_ok;
    logic [5:0]       bit_shift;
    logic [63:0]      byte_mask;
    logic [63:0]      lane_mask;
    logic [63:0]      old_val;
    logic [63:0]      merged;
    logic             wr_go;
    logic [1:0]       gcfg_d, gcfg_q;
    logic [63:0]      cnt_q;
    logic             unused_addr;

    logic [REG_W-1:0] cfg_w   [NUM_CH];
    logic [REG_W-1:0] cmp_w   [NUM_CH];
    logic [REG_W-1:0] route_w [NUM_CH];

    assign win_off     = req_addr[WIN_W-1:0];
    assign unused_addr = ^req_addr;

    evtmr_access u_access (
        .lo_addr   (win_off[2:0]),
        .len       (req_len),
        .acc_ok    (acc_ok),
        .bit_shift (bit_shift),
        .byte_mask (byte_mask),
        .lane_mask (lane_mask)
    );

    always_comb begin
        word_off = {win_off[WIN_W-1:3], 3'b000};
        ch_rel   = word_off - OFF_CH_BASE;
        ch_idx   = ch_rel[9:5];
        sel      = SEL_NONE;
        if (word_off == OFF_CAP)        sel = SEL_CAP;
        else if (word_off == OFF_GCFG)  sel = SEL_GCFG;
        else if (word_off == OFF_STAT)  sel = SEL_STAT;
        else if (word_off == OFF_COUNT) sel = SEL_COUNT;
        else if (word_off >= OFF_CH_BASE && ch_idx < 5'(NUM_CH)) begin
            case (ch_rel[4:0])
                SUB_CFG:   sel = SEL_CCFG;
                SUB_CMP:   sel = SEL_CCMP;
                SUB_ROUTE: sel = SEL_CROUTE;
                default:   sel = SEL_NONE;
            endcase
        end
    end

    always_comb begin
        old_val = '0;
        case (sel)
            SEL_CAP:   old_val = CAP_WORD;
            SEL_GCFG:  old_val = {62'd0, gcfg_q};
            SEL_COUNT: old_val = cnt_q;
            SEL_CCFG, SEL_CCMP, SEL_CROUTE: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (ch_idx == 5'(i)) begin
                        if (sel == SEL_CCFG)      old_val = cfg_w[i];
                        else if (sel == SEL_CCMP) old_val = cmp_w[i];
                        else                      old_val = route_w[i];
                    end
                end
            end
            default:   old_val = '0;
        endcase
    end

    always_comb begin
        merged  = ((req_wdata << bit_shift) & lane_mask) | (old_val & ~lane_mask);
        wr_go   = req_valid && req_write && acc_ok;
        rd_data = acc_ok ? ((old_val >> bit_shift) & byte_mask) : '1;
    end

    always_comb begin
        gcfg_d = gcfg_q;
        if (wr_go && sel == SEL_GCFG)
            gcfg_d = merged[1:0] & GCFG_WMASK[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gcfg_q <= '0;
        else        gcfg_q <= gcfg_d;
    end

    evtmr_counter #(.W(64)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (gcfg_q[0]),
        .tick_en  (tick_en),
        .load     (wr_go && sel == SEL_COUNT),
        .load_val (merged),
        .cnt_q    (cnt_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        evtmr_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cfg   (wr_go && sel == SEL_CCFG   && ch_idx == 5'(g)),
            .wr_cmp   (wr_go && sel == SEL_CCMP   && ch_idx == 5'(g)),
            .wr_route (wr_go && sel == SEL_CROUTE && ch_idx == 5'(g)),
            .wval     (merged),
            .cfg_q    (cfg_w[g]),
            .cmp_q    (cmp_w[g]),
            .route_q  (route_w[g])
        );
        assign ch_cfg[g*REG_W +: REG_W]   = cfg_w[g];
        assign ch_cmp[g*REG_W +: REG_W]   = cmp_w[g];
        assign ch_route[g*REG_W +: REG_W] = route_w[g];
    end

    assign glb_enable   = gcfg_q[0];
    assign legacy_route = gcfg_q[1];
    assign main_count   = cnt_q;

    // R2
    rej_write_gcfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !acc_ok) |=> $stable(gcfg_q));

    // R12
    undecoded_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && sel == SEL_NONE) |=> $stable(gcfg_q));

    // R2
    rej_write_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !acc_ok && !(gcfg_q[0] && tick_en))
            |=> $stable(cnt_q));
endmodule

// File: tb/evtmr_regbank_bench.sv
module evtmr_regbank_bench;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [15:0]   req_addr = '0;
    logic [3:0]    req_len = 4'd8;
    logic [63:0]   req_wdata = '0;
    logic [63:0]   rd_data;
    logic          glb_enable;
    logic          legacy_route;
    logic [63:0]   main_count;
    logic [191:0]  ch_cfg;
    logic [191:0]  ch_cmp;
    logic [191:0]  ch_route;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    evtmr_regbank u_evtmr_regbank (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_len      (req_len),
        .req_wdata    (req_wdata),
        .rd_data      (rd_data),
        .glb_enable   (glb_enable),
        .legacy_route (legacy_route),
        .main_count   (main_count),
        .ch_cfg       (ch_cfg),
        .ch_cmp       (ch_cmp),
        .ch_route     (ch_route)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [3:0]  len;
        logic [63:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 4'd8, 64'h0098_9680_8086_A201, 8'd7},  // R7
        '{1'b0, 16'h0004, 4'd4, 64'h0000_0000_0098_9680, 8'd3},  // R3
        '{1'b0, 16'h0001, 4'd1, 64'h0000_0000_0000_00A2, 8'd3},  // R3
        '{1'b0, 16'h0100, 4'd8, 64'h00F0_0000_0000_0030, 8'd8},  // R8
        '{1'b0, 16'h0148, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 8'd8},  // R8
        '{1'b0, 16'h0003, 4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 8'd2},  // R2
        '{1'b1, 16'h0010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 8'd5},  // R5
        '{1'b0, 16'h0010, 4'd8, 64'h0000_0000_0000_0003, 8'd5},  // R5
        '{1'b1, 16'h0010, 4'd1, 64'h0000_0000_0000_0000, 8'd5},  // R5
        '{1'b0, 16'h0010, 4'd8, 64'h0000_0000_0000_0000, 8'd5},  // R5
        '{1'b1, 16'h0100, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 8'd6},  // R6
        '{1'b0, 16'h0100, 4'd8, 64'h00F0_0000_0000_3F7E, 8'd6},  // R6
        '{1'b0, 16'h0108, 4'd8, 64'h0000_0000_FFFF_FFFF, 8'd9},  // R9
        '{1'b1, 16'h012A, 4'd2, 64'h0000_0000_0000_1234, 8'd4},  // R4
        '{1'b0, 16'h0128, 4'd8, 64'hFFFF_FFFF_1234_FFFF, 8'd4},  // R4
        '{1'b1, 16'h0154, 4'd4, 64'h0000_0000_DEAD_BEEF, 8'd14}, // R14
        '{1'b0, 16'h0150, 4'd8, 64'hDEAD_BEEF_0000_0000, 8'd14}, // R14
        '{1'b0, 16'h0156, 4'd2, 64'h0000_0000_0000_DEAD, 8'd3},  // R3
        '{1'b1, 16'h012C, 4'd8, 64'h0000_0000_0000_0000, 8'd2},  // R2
        '{1'b0, 16'h0128, 4'd8, 64'hFFFF_FFFF_1234_FFFF, 8'd2},  // R2
        '{1'b0, 16'h0000, 4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 8'd2},  // R2
        '{1'b0, 16'h0508, 4'd8, 64'h0000_0000_FFFF_FFFF, 8'd1},  // R1
        '{1'b1, 16'h0200, 4'd8, 64'h1111_2222_3333_4444, 8'd12}, // R12
        '{1'b0, 16'h0200, 4'd8, 64'h0000_0000_0000_0000, 8'd12}  // R12
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [3:0] l, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = a; req_len = l; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [3:0] l, output logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = a; req_len = l;
        #1;
        d = rd_data;
        req_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state of counter and global configuration outputs
        check("R8 count", main_count, 64'd0);
        check("R8 enable", {63'd0, glb_enable}, 64'd0);
        check("R8 route", ch_route[0 +: 64], 64'd0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].len, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, VECS[i].len, rv);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rv, VECS[i].data);
            end
        end

        // R12 status reads zero
        bus_read(16'h0020, 4'd8, rv);
        check("R12 status", rv, 64'd0);

        // R13 exported channel values
        check("R13 cfg0", ch_cfg[0 +: 64], 64'h00F0_0000_0000_3F7E);
        check("R13 cmp1", ch_cmp[64 +: 64], 64'hFFFF_FFFF_1234_FFFF);
        check("R13 route2", ch_route[128 +: 64], 64'hDEAD_BEEF_0000_0000);

        // R10 counting while enabled
        bus_write(16'h00F0, 4'd8, 64'h55);
        bus_read(16'h00F0, 4'd8, rv);
        check("R11 load halted", rv, 64'h55);
        bus_write(16'h0010, 4'd1, 64'h1);
        check("R13 glb_enable", {63'd0, glb_enable}, 64'd1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
        bus_read(16'h00F0, 4'd8, rv);
        check("R10 counted", rv, 64'h5A);

        // R10 frozen while disabled
        bus_write(16'h0010, 4'd1, 64'h0);
        @(negedge clk); tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        bus_read(16'h00F0, 4'd8, rv);
        check("R10 frozen", rv, 64'h5A);

        // R11 write wins over a same-cycle increment, then counting resumes
        bus_write(16'h0010, 4'd1, 64'h1);
        @(negedge clk);
        tick_en = 1'b1;
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = 16'h00F0; req_len = 4'd8; req_wdata = 64'h1000;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        bus_read(16'h00F0, 4'd8, rv);
        check("R11 priority", rv, 64'h1000);
        @(negedge clk);
        bus_read(16'h00F0, 4'd8, rv);
        check("R11 resume", rv, 64'h1001);
        tick_en = 1'b0;
        check("R13 main_count", main_count, 64'h1001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule